// File: doc/BRIEF.md
# Synchronous Serial Byte Receiver

This block takes in one byte over a two-wire synchronous link in which the block itself drives the shift clock. Timing comes from a machine-cycle strobe: one serial bit is taken per machine cycle. The shift clock is low for the first half of each active machine cycle and high for the second half. The serial input is captured where the shift clock rises.

A reception begins on a strobe edge when the receive enable is high and the completion flag is low. The shift register is then loaded with seven ones above a single zero. Each later machine cycle shifts the register left by one place and brings the captured bit in at the right. When the marker zero has reached the top position, the block makes one final shift and copies the byte into the read buffer with its bits reversed. The first bit received therefore lands in bit 0. It also raises the completion flag. No bit counter is used. Software-side logic clears the flag with a pulse, and a new reception can only begin after that.

Top module: `sync_rx_shifter`

## Requirements
- R1: After reset, rx_buf is 0 and rx_done, rx_active and shift_clk are all 0.
- R2: A reception starts on a clock edge where mc_stb=1, rx_en=1 and rx_done=0. rx_active is 1 from that edge onward. With rx_en=0 no reception ever starts.
- R3: The strobe period is MC_DIV clocks (default 12). While rx_active=1, shift_clk is 0 for the first MC_DIV/2 clocks after each strobe edge and 1 for the remaining clocks. While rx_active=0, shift_clk is 0.
- R4: ser_in is captured on the clock edge at which shift_clk goes from 0 to 1. That captured value is the bit shifted in at the next strobe edge.
- R5: A reception lasts exactly DATA_W (default 8) machine cycles. On the DATA_W-th strobe edge after the start edge, rx_active falls and rx_done rises.
- R6: Bit order is LSB first. The bit captured in the k-th machine cycle of a reception appears in rx_buf[k], so the first bit is in rx_buf[0].
- R7: A one-clock pulse on ri_clr clears rx_done on the next edge.
- R8: While rx_done=1, no reception starts, even when rx_en=1 and strobes arrive.
- R9: If rx_en is 0 during a reception, rx_active is 0 after the next clock edge. rx_buf and rx_done keep their values.
- R10: rx_buf changes only when a reception completes, and it holds that value across ri_clr and later idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_stb | input | 1 | One-clock pulse that ends each machine cycle |
| rx_en | input | 1 | Receive enable |
| ser_in | input | 1 | Serial data input |
| ri_clr | input | 1 | Pulse that clears rx_done |
| rx_buf | output | DATA_W | Last completed byte, first bit received in bit 0 |
| rx_done | output | 1 | Reception-complete flag |
| rx_active | output | 1 | High while a reception is in progress |
| shift_clk | output | 1 | Shift clock driven to the far end |

## Verification
A start becomes visible on rx_active one clock after the strobe edge that triggers it. shift_clk rises MC_DIV/2 clocks after each strobe edge. The byte and rx_done appear one clock after the DATA_W-th strobe edge. An abort or a flag clear shows one clock after the input that causes it. The bench's reference model advances on the same edges and is compared on the falling edge after each of them, so every result is checked in the cycle it becomes due. Directed checks also count active clocks (DATA_W·MC_DIV) and high shift-clock clocks (DATA_W·MC_DIV/2) over a full reception.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  // what the controller does on a given clock edge
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_START = 2'd1,
    EV_SHIFT = 2'd2,
    EV_FINAL = 2'd3
  } rx_event_e;
endpackage

// File: rtl/srx_phase.sv
module srx_phase #(
  parameter int MC_DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic mc_stb,
  output logic hi_next,
  output logic rise_now
);
  localparam int HALF = MC_DIV / 2;
  localparam int CW   = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (mc_stb)
      cnt_d = '0;
    else if (cnt_q == CW'(MC_DIV - 1))
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign hi_next  = (cnt_d >= CW'(HALF));
  assign rise_now = !mc_stb && (cnt_d == CW'(HALF));
endmodule

// File: rtl/srx_shreg.sv
module srx_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic              din,
  output logic [DATA_W-1:0] q,
  output logic              marker_top
);
  localparam logic [DATA_W-1:0] PRELOAD = {{(DATA_W-1){1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (rst)        q <= '1;
    else if (load)  q <= PRELOAD;
    else if (shift) q <= {q[DATA_W-2:0], din};
  end

  // the marker zero has reached the top position: next shift is the last
  assign marker_top = ~q[DATA_W-1];
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import sync_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mc_stb,
  input  logic rx_en,
  input  logic ri_clr,
  input  logic marker_top,
  output logic load,
  output logic shift,
  output logic done,
  output logic act_q,
  output logic act_d,
  output logic ri_q
);
  rx_event_e ev;

  always_comb begin
    ev    = EV_IDLE;
    act_d = act_q;
    if (act_q && !rx_en) begin
      act_d = 1'b0;
    end else if (mc_stb) begin
      if (act_q) begin
        if (marker_top) begin
          ev    = EV_FINAL;
          act_d = 1'b0;
        end else begin
          ev = EV_SHIFT;
        end
      end else if (rx_en && !ri_q) begin
        ev    = EV_START;
        act_d = 1'b1;
      end
    end
  end

  assign load  = (ev == EV_START);
  assign shift = (ev == EV_SHIFT) || (ev == EV_FINAL);
  assign done  = (ev == EV_FINAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      ri_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      if (done)        ri_q <= 1'b1;
      else if (ri_clr) ri_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter #(
  parameter int DATA_W = 8,
  parameter int MC_DIV = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_stb,
  input  logic              rx_en,
  input  logic              ser_in,
  input  logic              ri_clr,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_done,
  output logic              rx_active,
  output logic              shift_clk
);
  logic hi_next, rise_now;
  logic load, shift, done, act_q, act_d, ri_q, marker_top;
  logic samp_q;
  logic [DATA_W-1:0] sreg_q;
  logic [DATA_W-1:0] word_nxt;
  logic [DATA_W-1:0] word_rev;

  srx_phase #(.MC_DIV(MC_DIV)) u_phase (
    .clk(clk), .rst(rst), .mc_stb(mc_stb),
    .hi_next(hi_next), .rise_now(rise_now)
  );

  srx_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk(clk), .rst(rst), .load(load), .shift(shift), .din(samp_q),
    .q(sreg_q), .marker_top(marker_top)
  );

  srx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mc_stb(mc_stb), .rx_en(rx_en), .ri_clr(ri_clr),
    .marker_top(marker_top), .load(load), .shift(shift), .done(done),
    .act_q(act_q), .act_d(act_d), .ri_q(ri_q)
  );

  // capture the line where the shift clock rises
  always_ff @(posedge clk) begin
    if (rst)           samp_q <= 1'b0;
    else if (rise_now) samp_q <= ser_in;
  end

  assign word_nxt = {sreg_q[DATA_W-2:0], samp_q};

  // the first bit ends up at the top of the register: reverse into the buffer
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign word_rev[i] = word_nxt[DATA_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf    <= '0;
      shift_clk <= 1'b0;
    end else begin
      if (done) rx_buf <= word_rev;
      shift_clk <= act_d && hi_next;
    end
  end

  assign rx_done   = ri_q;
  assign rx_active = act_q;
endmodule

// File: rtl/sync_rx_shifter_chk.sv
module sync_rx_shifter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mc_stb,
  input logic              rx_en,
  input logic              ri_clr,
  input logic [DATA_W-1:0] rx_buf,
  input logic              rx_done,
  input logic              rx_active,
  input logic              shift_clk
);
  p_start_cond_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_active) |-> $past(mc_stb) && $past(rx_en) && !$past(rx_done));

  p_idle_clk_low_r3: assert property (@(posedge clk) disable iff (rst)
    !rx_active |-> !shift_clk);

  p_done_ends_rx_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(rx_active) && !rx_active);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(ri_clr) && !$past(rx_active) |-> !rx_done);

  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rx_done) |-> !$rose(rx_active));

  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rx_active) && !$past(rx_en) |-> !rx_active && !$rose(rx_done) && $stable(rx_buf));

  p_buf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$rose(rx_done) |-> $stable(rx_buf));
endmodule

bind sync_rx_shifter sync_rx_shifter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mc_stb(mc_stb), .rx_en(rx_en), .ri_clr(ri_clr),
  .rx_buf(rx_buf), .rx_done(rx_done), .rx_active(rx_active), .shift_clk(shift_clk)
);

// File: tb/sync_rx_shifter_test.sv
module sync_rx_shifter_test;
  localparam int W    = 8;
  localparam int MC   = 12;
  localparam int HALF = MC / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc_stb = 1'b0, rx_en = 1'b0, ser_in = 1'b0, ri_clr = 1'b0;
  logic [W-1:0] rx_buf;
  logic rx_done, rx_active, shift_clk;

  int n_chk = 0, n_bad = 0, ph = 0;
  int act_cnt = 0, sclk_cnt = 0;
  logic b_en = 1'b0, b_ser = 1'b0, b_clr = 1'b0;

  // reference model state
  int m_cnt = 0, m_nbits = 0;
  logic m_act = 0, m_ri = 0, m_samp = 0, m_sclk = 0;
  logic [W-1:0] m_buf = '0, m_byte = '0;

  always #4 clk = ~clk;

  sync_rx_shifter #(.DATA_W(W), .MC_DIV(MC)) uut (
    .clk(clk), .rst(rst), .mc_stb(mc_stb), .rx_en(rx_en), .ser_in(ser_in),
    .ri_clr(ri_clr), .rx_buf(rx_buf), .rx_done(rx_done),
    .rx_active(rx_active), .shift_clk(shift_clk)
  );

  // behavioural model: counts received bits instead of tracking a marker
  always @(posedge clk) begin
    int cn;
    logic set_ri;
    set_ri = 0;
    if (rst) begin
      m_cnt = 0; m_act = 0; m_ri = 0; m_samp = 0; m_sclk = 0; m_buf = '0; m_nbits = 0;
    end else begin
      cn = mc_stb ? 0 : ((m_cnt == MC-1) ? m_cnt : m_cnt + 1);
      if (m_act && !rx_en) m_act = 0;
      else if (mc_stb) begin
        if (m_act) begin
          m_byte[m_nbits] = m_samp;
          m_nbits++;
          if (m_nbits == W) begin m_buf = m_byte; set_ri = 1; m_act = 0; end
        end else if (rx_en && !m_ri) begin
          m_act = 1; m_nbits = 0; m_byte = '0;
        end
      end
      if (set_ri) m_ri = 1; else if (ri_clr) m_ri = 0;
      if (!mc_stb && cn == HALF) m_samp = ser_in;
      m_sclk = m_act && (cn >= HALF);
      m_cnt = cn;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(rx_buf == m_buf, "R6 model rx_buf", rx_buf, m_buf);
    check(rx_done == m_ri, "R5 model rx_done", rx_done, m_ri);
    check(rx_active == m_act, "R2 model rx_active", rx_active, m_act);
    check(shift_clk == m_sclk, "R3 model shift_clk", shift_clk, m_sclk);
    if (rx_active) act_cnt++;
    if (shift_clk) sclk_cnt++;
    mc_stb = (ph == MC-1);
    ph = (ph + 1) % MC;
    rx_en = b_en; ser_in = b_ser; ri_clr = b_clr;
  endtask

  task automatic wait_stb();
    do step(); while (mc_stb !== 1'b1);
  endtask

  task automatic recv(input logic [W-1:0] b);
    b_en = 1; b_clr = 0;
    wait_stb();
    act_cnt = 0; sclk_cnt = 0;
    for (int k = 0; k < W; k++) begin
      b_ser = b[k];
      repeat (MC) step();
    end
    step();
    check(rx_buf == b, "R6 byte LSB first", rx_buf, b);
    check(rx_done == 1'b1, "R5 done after final shift", rx_done, 1);
    check(rx_active == 1'b0, "R5 active ends", rx_active, 0);
    check(act_cnt == W*MC, "R5 active length", act_cnt, W*MC);
    check(sclk_cnt == W*HALF, "R3 shift clock high time", sclk_cnt, W*HALF);
  endtask

  task automatic clear_ri();
    b_clr = 1; step(); b_clr = 0; step(); step();
    check(rx_done == 1'b0, "R7 clear", rx_done, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] keep;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(rx_buf == 0 && !rx_done && !rx_active && !shift_clk, "R1 reset state",
          {rx_done, rx_active, shift_clk}, 0);

    // R2: enable low, no start
    b_en = 0; act_cnt = 0;
    repeat (3*MC) step();
    check(act_cnt == 0, "R2 no start with rx_en low", act_cnt, 0);

    recv(8'hA5);
    // R8: flag set, enable high, strobes keep coming
    act_cnt = 0;
    repeat (4*MC) step();
    check(act_cnt == 0, "R8 no restart while done", act_cnt, 0);
    clear_ri();
    check(rx_buf == 8'hA5, "R10 buffer held after clear", rx_buf, 8'hA5);
    repeat (MC) step();
    check(rx_active == 1'b1, "R8 restart after clear", rx_active, 1);

    b_en = 0; step(); step();
    recv(8'h3C); clear_ri();
    recv(8'h01); clear_ri();
    recv(8'h80); clear_ri();
    recv(8'hFF); clear_ri();

    // R9: abort mid-byte
    keep = rx_buf;
    b_en = 1; b_ser = 1;
    wait_stb();
    repeat (3*MC + 2) step();
    check(rx_active == 1'b1, "R9 active before abort", rx_active, 1);
    b_en = 0; step(); step();
    check(rx_active == 1'b0, "R9 abort drops active", rx_active, 0);
    check(rx_done == 1'b0, "R9 abort leaves done", rx_done, 0);
    check(rx_buf == keep, "R9 abort leaves buffer", rx_buf, keep);
    repeat (2*MC) step();
    check(rx_buf == keep, "R10 buffer idle hold", rx_buf, keep);

    // R4: data changed only in first half must not matter when held across rise
    recv(8'h5A); clear_ri();
    recv(8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule